// File: doc/BRIEF.md
# Serial memory slave interface with hold

This block is the pin-facing serial front-end of a memory device that is accessed over a four-wire SPI link. It samples chip select, serial clock, serial data in and the active-low hold pin on a fast system clock. Each byte shifted in on the rising edges of the serial clock is handed to a downstream command decoder. Response bytes supplied by that decoder are shifted out on the falling edges of the serial clock. The block also drives the enable of the tri-state data output.

A hold pin lets the bus master pause a transfer in the middle of a byte without ending it. While the pause lasts, the output floats and the partial byte and the bit position are kept. A standby indication is raised once the device is deselected. If an internal self-timed operation is still running, the indication waits until that operation's busy input falls.

The serial clock must toggle at most once every four system clock cycles. All four pins pass through a two-stage synchronizer. An edge is found by comparing two successive synchronized samples.

Top module: `spi_fe_top`

## Requirements
- R1: Bits on `si` are captured on serial clock rising edges, most significant bit first. After the eighth captured bit of a selected transfer, `rx_valid` pulses high for exactly one system clock with the assembled byte on `rx_byte`.
- R2: While `cs_n` is high, serial clock edges and `si` data produce no `rx_valid` pulse.
- R3: Raising `cs_n` before eight bits have been captured discards the partial byte without a strobe. The next selected transfer starts at bit 7 of a new byte.
- R4: A byte loaded with a one-cycle `tx_load` pulse drives its bit 7 on `so` from the next serial clock falling edge. Lower bits follow on each later falling edge. Once the loaded bits are used up and no new byte has been loaded, `so` carries zeros.
- R5: While `cs_n` is high, `so_oe` is low.
- R6: A falling edge of `hold_n` while selected and with the serial clock low starts a pause. During the pause `so_oe` is low and serial clock edges and `si` are ignored. The bit count and both shift registers keep their values, so after `hold_n` rises the byte in flight completes correctly in both directions.
- R7: A falling edge of `hold_n` seen while the serial clock is high is ignored: the transfer continues and `so_oe` stays high.
- R8: `standby` is low while selected. After deselect it rises only when `busy` is low, and it stays low for as long as `busy` stays high.
- R9: During reset `rx_valid`, `so_oe` and `standby` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data in pin |
| hold_n | input | 1 | Hold pin, active low |
| busy | input | 1 | Internal self-timed operation in progress |
| tx_load | input | 1 | One-cycle strobe that loads `tx_byte` for transmission |
| tx_byte | input | 8 | Response byte from the command decoder |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` holds a completed byte |
| rx_byte | output | 8 | Last completed received byte |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so`; low means high-impedance |
| standby | output | 1 | Device deselected and idle |

## Verification
Every one of the 256 byte values is shifted in, which separates bit-order and off-by-one counting faults from correct assembly. The loaded response differs arithmetically from the received byte, so a swapped path shows up. Each response is followed by an unloaded byte that must read back as zeros, which exposes a stale shift register. A deselect part-way through a byte, a hold taken with the clock low, and a hold attempted with the clock high are each followed by a known byte. Only a correct discard, freeze or ignore reproduces that byte. A busy flag held across deselect tells deferred standby apart from immediate entry.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic si;
        logic hold_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, si: 1'b0, hold_n: 1'b1};

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic hold_fall;
        logic hold_rise;
    } edges_t;

    function automatic logic rose_f(input logic cur, input logic prv);
        return cur & ~prv;
    endfunction

    function automatic logic fell_f(input logic cur, input logic prv);
        return ~cur & prv;
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stg
        logic [W-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= g_stg[g-1].r;
            end
        end
    end

    assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx
    import spi_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  step,
    input  logic  din,
    output logic  valid,
    output byte_t data
);
    logic [CNT_W-1:0] cnt;
    byte_t            sh;
    byte_t            nxt;

    assign nxt = {sh[BYTE_W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sh    <= '0;
            valid <= 1'b0;
            data  <= '0;
        end else if (clr) begin
            cnt   <= '0;
            sh    <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (step) begin
                sh <= nxt;
                if (cnt == CNT_W'(BYTE_W - 1)) begin
                    cnt   <= '0;
                    valid <= 1'b1;
                    data  <= nxt;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx
    import spi_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  step,
    input  logic  load,
    input  byte_t load_data,
    output logic  dout
);
    byte_t pend;
    logic  pend_v;
    byte_t sh;
    byte_t src;
    logic  src_v;

    always_comb begin
        src_v = load | pend_v;
        src   = load ? load_data : pend;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend   <= '0;
            pend_v <= 1'b0;
            sh     <= '0;
            dout   <= 1'b0;
        end else if (step) begin
            pend_v <= 1'b0;
            if (src_v) begin
                dout <= src[BYTE_W-1];
                sh   <= {src[BYTE_W-2:0], 1'b0};
            end else begin
                dout <= sh[BYTE_W-1];
                sh   <= {sh[BYTE_W-2:0], 1'b0};
            end
        end else if (load) begin
            pend   <= load_data;
            pend_v <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
    import spi_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic       hold_n,
    input  logic       busy,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       so,
    output logic       so_oe,
    output logic       standby
);
    pins_t  raw, cur, prv;
    edges_t ev;
    logic   sel, held, shift_en, so_q;
    byte_t  rx_q;

    assign raw = '{cs_n: cs_n, sck: sck, si: si, hold_n: hold_n};

    spi_fe_sync #(
        .W      ($bits(pins_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw),
        .q  (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) prv <= PINS_IDLE;
        else     prv <= cur;
    end

    always_comb begin
        ev.sck_rise  = rose_f(cur.sck, prv.sck);
        ev.sck_fall  = fell_f(cur.sck, prv.sck);
        ev.hold_fall = fell_f(cur.hold_n, prv.hold_n);
        ev.hold_rise = rose_f(cur.hold_n, prv.hold_n);
    end

    assign sel = ~cur.cs_n;

    // Pause starts only on a hold edge taken with the clock low
    always_ff @(posedge clk) begin
        if (rst)                          held <= 1'b0;
        else if (!sel || ev.hold_rise)    held <= 1'b0;
        else if (ev.hold_fall && !cur.sck) held <= 1'b1;
    end

    assign shift_en = sel & ~held;

    spi_fe_rx u_rx (
        .clk  (clk),
        .rst  (rst),
        .clr  (~sel),
        .step (shift_en & ev.sck_rise),
        .din  (cur.si),
        .valid(rx_valid),
        .data (rx_q)
    );

    spi_fe_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .clr      (~sel),
        .step     (shift_en & ev.sck_fall),
        .load     (tx_load),
        .load_data(byte_t'(tx_byte)),
        .dout     (so_q)
    );

    // Standby waits for the internal operation to finish
    always_ff @(posedge clk) begin
        if (rst) standby <= 1'b0;
        else     standby <= ~sel & ~busy;
    end

    assign rx_byte = rx_q;
    assign so_oe   = shift_en;
    assign so      = shift_en & so_q;
endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic busy,
    input logic rx_valid,
    input logic so_oe,
    input logic standby
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 3'd7) age <= age + 1'b1;
    end

    // R1
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R2
    idle_no_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
        |-> !rx_valid);

    // R5
    idle_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
        |-> !so_oe);

    // R8
    standby_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd1 && standby) |-> !$past(busy));

    // R8
    sel_no_standby_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4 && !cs_n && !$past(cs_n) && !$past(cs_n, 2) && !$past(cs_n, 3))
        |-> !standby);
endmodule

bind spi_fe_top spi_fe_chk u_chk (.*);

// File: tb/spi_fe_top_bench.sv
module spi_fe_top_bench;
    localparam int H = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       rx_valid, so, so_oe, standby;
    logic [7:0] rx_byte;

    int n_chk = 0, n_bad = 0, rx_cnt = 0;
    logic [7:0] rx_last = '0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_fe_top u_spi_fe_top (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .busy(busy), .tx_load(tx_load), .tx_byte(tx_byte), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .so(so), .so_oe(so_oe), .standby(standby)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_byte;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_bit(input logic b, input logic ld, input logic [7:0] lv, output logic so_s);
        si = b;
        wait_n(H);
        so_s = so;
        sck = 1'b1;
        wait_n(2);
        if (ld) begin
            tx_byte = lv; tx_load = 1'b1;
            wait_n(1);
            tx_load = 1'b0;
            wait_n(H - 3);
        end else begin
            wait_n(H - 2);
        end
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] d, input logic ld, input logic [7:0] lv, output logic [7:0] sb);
        for (int i = 7; i >= 0; i--) do_bit(d[i], ld && (i == 0), lv, sb[i]);
    endtask

    task automatic select_dev();
        cs_n = 1'b0; wait_n(H);
    endtask

    task automatic deselect_dev();
        wait_n(H); cs_n = 1'b1; wait_n(H);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s0, s1, s2, w;
        logic sb;
        int c0;

        // R9 reset state
        wait_n(4);
        check(rx_valid, 0, "R9 rx_valid");
        check(so_oe, 0, "R9 so_oe");
        check(standby, 0, "R9 standby");
        rst = 1'b0;
        wait_n(10);
        check(standby, 1, "R8 standby after reset idle");

        // R1 / R4 sweep over all byte values
        for (int v = 0; v < 256; v++) begin
            w = 8'((v * 37 + 11) % 256);
            c0 = rx_cnt;
            select_dev();
            check(so_oe, 1, "R5 so_oe selected");
            check(standby, 0, "R8 standby selected");
            xfer(8'(v), 1'b1, w, s0);
            wait_n(H);
            check(rx_cnt, c0 + 1, "R1 strobe count");
            check(rx_last, 32'(v), "R1 byte value");
            xfer(8'h00, 1'b0, 8'h00, s1);
            check(s1, w, "R4 loaded byte on so");
            xfer(8'h00, 1'b0, 8'h00, s2);
            check(s2, 0, "R4 zeros when nothing loaded");
            deselect_dev();
        end

        // R2 / R5 clocking while deselected
        c0 = rx_cnt;
        for (int i = 0; i < 16; i++) begin
            si = i[0]; sck = 1'b1; wait_n(H);
            check(so_oe, 0, "R5 so_oe deselected");
            sck = 1'b0; wait_n(H);
        end
        check(rx_cnt, c0, "R2 no strobe while deselected");

        // R3 deselect mid-byte
        c0 = rx_cnt;
        select_dev();
        for (int i = 0; i < 5; i++) do_bit(1'b1, 1'b0, 8'h00, sb);
        deselect_dev();
        check(rx_cnt, c0, "R3 partial byte discarded");
        select_dev();
        xfer(8'hA5, 1'b0, 8'h00, s0);
        wait_n(H);
        check(rx_cnt, c0 + 1, "R3 one strobe after restart");
        check(rx_last, 32'hA5, "R3 fresh alignment");
        deselect_dev();

        // R6 hold with clock low
        select_dev();
        xfer(8'h11, 1'b1, 8'h96, s0);
        c0 = rx_cnt;
        for (int i = 7; i >= 4; i--) do_bit(8'hC3 >> i, 1'b0, 8'h00, s1[i]);
        wait_n(H);
        hold_n = 1'b0;
        wait_n(6);
        check(so_oe, 0, "R6 so_oe low in hold");
        for (int i = 0; i < 3; i++) begin
            si = ~si; sck = 1'b1; wait_n(H);
            sck = 1'b0; wait_n(H);
        end
        check(rx_cnt, c0, "R6 clocks ignored in hold");
        hold_n = 1'b1;
        wait_n(6);
        check(so_oe, 1, "R6 so_oe back after hold");
        for (int i = 3; i >= 0; i--) do_bit(8'hC3 >> i, 1'b0, 8'h00, s1[i]);
        wait_n(H);
        check(rx_cnt, c0 + 1, "R6 one strobe after resume");
        check(rx_last, 32'hC3, "R6 rx byte preserved");
        check(s1, 32'h96, "R6 tx byte preserved");
        deselect_dev();

        // R7 hold edge with clock high is ignored
        select_dev();
        c0 = rx_cnt;
        for (int i = 7; i >= 4; i--) do_bit(8'h3C >> i, 1'b0, 8'h00, sb);
        si = 1'b1; wait_n(H);
        sck = 1'b1; wait_n(2);
        hold_n = 1'b0; wait_n(H - 2 + 4);
        check(so_oe, 1, "R7 so_oe stays high");
        sck = 1'b0;
        for (int i = 2; i >= 0; i--) do_bit(8'h3C >> i, 1'b0, 8'h00, sb);
        wait_n(H);
        check(rx_cnt, c0 + 1, "R7 transfer continued");
        check(rx_last, 32'h3C, "R7 byte value");
        hold_n = 1'b1;
        deselect_dev();

        // R8 standby deferred by busy
        busy = 1'b1;
        select_dev();
        deselect_dev();
        wait_n(10);
        check(standby, 0, "R8 standby held off by busy");
        busy = 1'b0;
        wait_n(3);
        check(standby, 1, "R8 standby after busy clears");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule